// File: doc/BRIEF.md
# Processor Clock-Control Power-State Sequencer

This block follows the low-power clock-control state of a processor core. It moves between five states: Normal, Halt, Stop Grant, Stop Grant Inquire (bus snoop serviced while the core is idle) and Stop Clock. It reacts to a stop-clock request, a halt request, bus inquire strobes with their cache lookup result, writeback completion, and a clock-off indicator. That indicator comes from a free-running supervisory domain and stands for the bus clock being held stopped.

While the core sleeps, the interrupt-class inputs (init, maskable interrupt, cache flush, non-maskable interrupt, system-management interrupt) are recorded as pending flags and do not wake the core. The flags are presented through a one-cycle service pulse once the block is back in Normal. In Stop Clock the block only watches for misuse: any input other than the maskable interrupt that moves is reported as a protocol violation.

Top module: `clkctl_seq`

## Requirements
- R1: While `rst_n` is sampled low, on the next edge `pstate` becomes Normal (0) and every other output and all pending flags become 0. This applies from any state, Stop Grant included.
- R2: State codes are 0 Normal, 1 Halt, 2 Stop Grant, 3 Stop Grant Inquire, 4 Stop Clock. From Normal, `stop_req` high moves to Stop Grant, else `halt_req` high moves to Halt. From Halt, `stop_req` moves to Stop Grant, and `halt_req` low returns to Normal.
- R3: In Stop Grant, with no inquire strobe and no synchronized clock-off, `stop_req` low returns the block to Normal on the next edge.
- R4: A rising edge on `irq_init`, `irq_flush`, `irq_nmi` or `irq_smi`, sampled in any state except Stop Clock, sets `irq_pend` bit 0, 2, 3 or 4 one cycle later. It never changes `pstate`.
- R5: `irq_intr` sampled high with `irq_enable` high, outside Stop Clock, sets `irq_pend` bit 1. With `irq_enable` low it has no effect. It never changes `pstate`.
- R6: `irq_svc` rises one cycle after a cycle in Normal with any pending flag, and lasts exactly one cycle. The flags clear at the edge that ends the pulse, but an edge sampled in that same cycle stays pending. There is no pulse outside Normal.
- R7: An inquire strobe sampled in Normal, Halt or Stop Grant pulses `snoop_hit_o` one cycle later when `snoop_hit` is high. It pulses `snoop_dirty_o` when both `snoop_hit` and `snoop_dirty` are high. From Halt or Stop Grant it enters Stop Grant Inquire. In Stop Grant the strobe has priority over clock-off and over a dropped `stop_req`.
- R8: `wb_req` rises one cycle after a strobe that hits a dirty line, and stays high until `wb_done` is sampled high.
- R9: Stop Grant Inquire is left when no writeback is outstanding or `wb_done` is sampled high, and the block then returns to the state the inquire came from.
- R10: `clk_off_async` passes through two flops. In Stop Grant, a high synchronized value moves to Stop Clock on the third edge after the input rises. In Stop Clock, a low value returns to Stop Grant after the same latency. Clock-off has no effect in Normal or Halt.
- R11: In Stop Clock, `irq_intr` is not sampled: it sets no flag and raises no violation. A level still high after the return to Stop Grant is taken then.
- R12: `proto_viol` pulses one cycle after a Stop Clock cycle in which any input other than `irq_intr` and `clk_off_async` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Stop-clock request, active high |
| halt_req | input | 1 | Halt entry request, level |
| snoop_stb | input | 1 | Bus inquire strobe |
| snoop_hit | input | 1 | Inquire lookup hit |
| snoop_dirty | input | 1 | Inquire lookup found a modified line |
| wb_done | input | 1 | Writeback completed |
| clk_off_async | input | 1 | Clock-stopped indicator, asynchronous |
| irq_enable | input | 1 | Maskable interrupts enabled |
| irq_init | input | 1 | Init request, edge |
| irq_intr | input | 1 | Maskable interrupt, level |
| irq_flush | input | 1 | Cache flush request, edge |
| irq_nmi | input | 1 | Non-maskable interrupt, edge |
| irq_smi | input | 1 | System-management interrupt, edge |
| pstate | output | 3 | Current power state code |
| snoop_hit_o | output | 1 | Inquire hit indication |
| snoop_dirty_o | output | 1 | Inquire modified-hit indication |
| wb_req | output | 1 | Writeback request |
| irq_pend | output | 5 | Pending interrupt flags |
| irq_svc | output | 1 | Interrupt service pulse |
| proto_viol | output | 1 | Stop Clock input-change violation |

## Verification
Two pairs of events can fall in the same cycle. In the first, an inquire strobe in Stop Grant arrives together with a dropped stop request, so the block must enter the inquire state, return to Stop Grant, and only then fall to Normal. In the second, a new interrupt edge lands in the cycle of the service pulse, so the new flag must survive the clear. The bench drives both coincidences on purpose. It judges each cycle against a behavioural model that computes the next state from the requirement priorities, including the two-flop delay on clock-off.

// File: rtl/clkctl_pkg.sv
// Shared types for the clock-control sequencer.
// Assumes: state codes are visible on the top-level port and are fixed.
package clkctl_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_HALT    = 3'd1,
        ST_GRANT   = 3'd2,
        ST_SNOOP   = 3'd3,
        ST_STOPPED = 3'd4
    } pstate_t;

    localparam int IRQ_N     = 5;
    localparam int IRQ_INIT  = 0;
    localparam int IRQ_INTR  = 1;
    localparam int IRQ_FLUSH = 2;
    localparam int IRQ_NMI   = 3;
    localparam int IRQ_SMI   = 4;
    // Bits set here are edge-captured; clear bits are level-captured.
    localparam logic [IRQ_N-1:0] IRQ_EDGE_MASK = 5'b11101;
endpackage

// File: rtl/clkctl_sync.sv
// Multi-flop synchronizer for a slow level from another clock domain.
// Assumes: STAGES >= 2 and the input level is held for several cycles.
module clkctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkctl_pend.sv
// Pending-interrupt capture: one flag per source, edge- or level-captured
// as EDGE_MASK selects. Assumes clear and capture may coincide; capture wins.
module clkctl_pend #(
    parameter int             N         = 5,
    parameter logic [N-1:0]   EDGE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_en,
    input  logic         clear,
    input  logic [N-1:0] raw,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev;
    logic [N-1:0] fire;

    for (genvar i = 0; i < N; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign fire[i] = raw[i] & ~prev[i];
        end else begin : g_level
            assign fire[i] = raw[i];
        end
    end

    // Track last input values and merge new captures into the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= raw;
            pend <= (clear ? '0 : pend) | (sample_en ? fire : '0);
        end
    end
endmodule

// File: rtl/clkctl_fsm.sv
// Power-state machine with inquire handling and writeback tracking.
// Assumes clk_off is already synchronized to clk.
module clkctl_fsm
    import clkctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stop_req,
    input  logic    halt_req,
    input  logic    snoop_stb,
    input  logic    snoop_hit,
    input  logic    snoop_dirty,
    input  logic    wb_done,
    input  logic    clk_off,
    output pstate_t state_o,
    output pstate_t ret_o,
    output logic    hit_o,
    output logic    dirty_o,
    output logic    wb_o
);
    pstate_t state_q, state_d, ret_q;
    logic    wb_q, hit_q, dirty_q;
    logic    accept, take;

    assign accept = (state_q == ST_NORMAL) || (state_q == ST_HALT) ||
                    (state_q == ST_GRANT);
    assign take   = snoop_stb && accept;

    // Next-state selection with inquire taking priority while idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (stop_req)      state_d = ST_GRANT;
                else if (halt_req) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (take)           state_d = ST_SNOOP;
                else if (stop_req)  state_d = ST_GRANT;
                else if (!halt_req) state_d = ST_NORMAL;
            end
            ST_GRANT: begin
                if (take)           state_d = ST_SNOOP;
                else if (clk_off)   state_d = ST_STOPPED;
                else if (!stop_req) state_d = ST_NORMAL;
            end
            ST_SNOOP: begin
                if (!wb_q || wb_done) state_d = ret_q;
            end
            ST_STOPPED: begin
                if (!clk_off) state_d = ST_GRANT;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    // Register state, return point, lookup pulses and writeback flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            ret_q   <= ST_NORMAL;
            wb_q    <= 1'b0;
            hit_q   <= 1'b0;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take && state_q != ST_NORMAL) ret_q <= state_q;
            if (take && snoop_hit && snoop_dirty) wb_q <= 1'b1;
            else if (wb_done)                     wb_q <= 1'b0;
            hit_q   <= take && snoop_hit;
            dirty_q <= take && snoop_hit && snoop_dirty;
        end
    end

    assign state_o = state_q;
    assign ret_o   = ret_q;
    assign hit_o   = hit_q;
    assign dirty_o = dirty_q;
    assign wb_o    = wb_q;
endmodule

// File: rtl/clkctl_seq.sv
// Top of the clock-control sequencer: synchronizes the clock-off level,
// runs the state machine, captures interrupts, issues the service pulse
// and flags input changes during Stop Clock. Assumes a single core clock.
module clkctl_seq
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             halt_req,
    input  logic             snoop_stb,
    input  logic             snoop_hit,
    input  logic             snoop_dirty,
    input  logic             wb_done,
    input  logic             clk_off_async,
    input  logic             irq_enable,
    input  logic             irq_init,
    input  logic             irq_intr,
    input  logic             irq_flush,
    input  logic             irq_nmi,
    input  logic             irq_smi,
    output logic [2:0]       pstate,
    output logic             snoop_hit_o,
    output logic             snoop_dirty_o,
    output logic             wb_req,
    output logic [IRQ_N-1:0] irq_pend,
    output logic             irq_svc,
    output logic             proto_viol
);
    localparam int WATCH_W = 11;

    pstate_t            state, ret_state;
    logic               clk_off_s;
    logic [IRQ_N-1:0]   irq_raw;
    logic               svc_q, viol_q;
    logic [WATCH_W-1:0] watch, watch_prev;

    clkctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (clk_off_async),
        .q     (clk_off_s)
    );

    clkctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .halt_req    (halt_req),
        .snoop_stb   (snoop_stb),
        .snoop_hit   (snoop_hit),
        .snoop_dirty (snoop_dirty),
        .wb_done     (wb_done),
        .clk_off     (clk_off_s),
        .state_o     (state),
        .ret_o       (ret_state),
        .hit_o       (snoop_hit_o),
        .dirty_o     (snoop_dirty_o),
        .wb_o        (wb_req)
    );

    always_comb begin
        irq_raw            = '0;
        irq_raw[IRQ_INIT]  = irq_init;
        irq_raw[IRQ_INTR]  = irq_intr && irq_enable;
        irq_raw[IRQ_FLUSH] = irq_flush;
        irq_raw[IRQ_NMI]   = irq_nmi;
        irq_raw[IRQ_SMI]   = irq_smi;
    end

    clkctl_pend #(.N(IRQ_N), .EDGE_MASK(IRQ_EDGE_MASK)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (state != ST_STOPPED),
        .clear     (svc_q),
        .raw       (irq_raw),
        .pend      (irq_pend)
    );

    assign watch = {stop_req, halt_req, snoop_stb, snoop_hit, snoop_dirty,
                    wb_done, irq_enable, irq_init, irq_flush, irq_nmi, irq_smi};

    // Service pulse in Normal and input-change watch during Stop Clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q      <= 1'b0;
            viol_q     <= 1'b0;
            watch_prev <= '0;
        end else begin
            svc_q      <= (state == ST_NORMAL) && (|irq_pend) && !svc_q;
            viol_q     <= (state == ST_STOPPED) && (watch != watch_prev);
            watch_prev <= watch;
        end
    end

    assign pstate     = state;
    assign irq_svc    = svc_q;
    assign proto_viol = viol_q;
endmodule

// File: rtl/clkctl_seq_chk.sv
// Property checker for clkctl_seq, attached by bind.
// Assumes it observes the top-level ports plus the remembered return state.
module clkctl_seq_chk
    import clkctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       pstate,
    input logic [2:0]       ret_state,
    input logic             wb_done,
    input logic             wb_req,
    input logic             snoop_hit_o,
    input logic             snoop_dirty_o,
    input logic [IRQ_N-1:0] irq_pend,
    input logic             irq_svc,
    input logic             proto_viol
);
    p_stop_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate != ST_STOPPED && pstate != ST_GRANT) |=> (pstate != ST_STOPPED));

    p_stopped_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_STOPPED) |=> $stable(irq_pend));

    p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> wb_req);

    p_snoop_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_SNOOP && wb_req && !wb_done) |=> (pstate == ST_SNOOP));

    p_snoop_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_SNOOP) |=> (pstate == ST_SNOOP || pstate == $past(ret_state)));

    p_svc_in_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_svc |-> ($past(pstate) == ST_NORMAL));

    p_svc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_svc |=> !irq_svc);

    p_dirty_implies_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_dirty_o |-> snoop_hit_o);

    p_viol_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        proto_viol |-> ($past(pstate) == ST_STOPPED));
endmodule

bind clkctl_seq clkctl_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pstate        (pstate),
    .ret_state     (ret_state),
    .wb_done       (wb_done),
    .wb_req        (wb_req),
    .snoop_hit_o   (snoop_hit_o),
    .snoop_dirty_o (snoop_dirty_o),
    .irq_pend      (irq_pend),
    .irq_svc       (irq_svc),
    .proto_viol    (proto_viol)
);

// File: tb/clkctl_seq_test.sv
`timescale 1ns/1ps
// Bench for clkctl_seq: behavioural next-cycle model compared every clock.
module clkctl_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, halt_req = 0, snoop_stb = 0, snoop_hit = 0, snoop_dirty = 0;
    logic wb_done = 0, clk_off_async = 0, irq_enable = 0;
    logic irq_init = 0, irq_intr = 0, irq_flush = 0, irq_nmi = 0, irq_smi = 0;
    logic [2:0] pstate;
    logic snoop_hit_o, snoop_dirty_o, wb_req, irq_svc, proto_viol;
    logic [4:0] irq_pend;

    int checks = 0;
    int fails  = 0;

    // Model state (state codes as in the requirements).
    int m_st = 0, m_ret = 0;
    bit m_wb = 0, m_hit = 0, m_dirty = 0, m_svc = 0, m_viol = 0, m_s1 = 0, m_s2 = 0;
    bit [4:0]  m_pend = 0, m_prev = 0;
    bit [10:0] m_wprev = 0;

    always #2.5 clk = ~clk;

    clkctl_seq uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .halt_req(halt_req),
        .snoop_stb(snoop_stb), .snoop_hit(snoop_hit), .snoop_dirty(snoop_dirty),
        .wb_done(wb_done), .clk_off_async(clk_off_async), .irq_enable(irq_enable),
        .irq_init(irq_init), .irq_intr(irq_intr), .irq_flush(irq_flush),
        .irq_nmi(irq_nmi), .irq_smi(irq_smi), .pstate(pstate),
        .snoop_hit_o(snoop_hit_o), .snoop_dirty_o(snoop_dirty_o), .wb_req(wb_req),
        .irq_pend(irq_pend), .irq_svc(irq_svc), .proto_viol(proto_viol)
    );

    task automatic model_tick();
        bit take, nwb;
        bit [4:0] raw, ev;
        bit [10:0] watch;
        int nst;
        if (!rst_n) begin
            m_st = 0; m_ret = 0; m_wb = 0; m_hit = 0; m_dirty = 0; m_svc = 0;
            m_viol = 0; m_s1 = 0; m_s2 = 0; m_pend = 0; m_prev = 0; m_wprev = 0;
            return;
        end
        take  = snoop_stb && (m_st <= 2);
        raw   = {irq_smi, irq_nmi, irq_flush, irq_intr && irq_enable, irq_init};
        ev    = raw & ~(m_prev & 5'b11101);
        watch = {stop_req, halt_req, snoop_stb, snoop_hit, snoop_dirty, wb_done,
                 irq_enable, irq_init, irq_flush, irq_nmi, irq_smi};
        nst = m_st;
        if (m_st == 0) nst = stop_req ? 2 : (halt_req ? 1 : 0);
        else if (m_st == 1) nst = take ? 3 : (stop_req ? 2 : (!halt_req ? 0 : 1));
        else if (m_st == 2) nst = take ? 3 : (m_s2 ? 4 : (!stop_req ? 0 : 2));
        else if (m_st == 3) nst = (!m_wb || wb_done) ? m_ret : 3;
        else nst = m_s2 ? 4 : 2;
        if (take && snoop_hit && snoop_dirty) nwb = 1;
        else nwb = wb_done ? 0 : m_wb;
        m_viol  = (m_st == 4) && (watch != m_wprev);
        m_pend  = (m_svc ? 5'b0 : m_pend) | ((m_st != 4) ? ev : 5'b0);
        m_svc   = (m_st == 0) && ((m_svc ? 5'b0 : 5'b1) != 0) && (m_pend_before_nonzero);
        m_hit   = take && snoop_hit;
        m_dirty = take && snoop_hit && snoop_dirty;
        if (take && m_st != 0) m_ret = m_st;
        m_wb = nwb; m_st = nst; m_s2 = m_s1; m_s1 = clk_off_async;
        m_prev = raw; m_wprev = watch;
    endtask

    bit m_pend_before_nonzero;

    task automatic step(input string tag);
        m_pend_before_nonzero = (m_pend != 0) && !m_svc;
        model_tick();
        @(posedge clk);
        #1;
        checks++;
        if (pstate !== m_st[2:0] || snoop_hit_o !== m_hit || snoop_dirty_o !== m_dirty ||
            wb_req !== m_wb || irq_pend !== m_pend || irq_svc !== m_svc ||
            proto_viol !== m_viol) begin
            fails++;
            $display("FAIL %s: got st=%0d hit=%b dirty=%b wb=%b pend=%b svc=%b viol=%b exp st=%0d hit=%b dirty=%b wb=%b pend=%b svc=%b viol=%b",
                     tag, pstate, snoop_hit_o, snoop_dirty_o, wb_req, irq_pend, irq_svc,
                     proto_viol, m_st, m_hit, m_dirty, m_wb, m_pend, m_svc, m_viol);
        end
        @(negedge clk);
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        steps(3, "R1");
        rst_n = 1;
        steps(2, "R1");
        // R2: Normal to Stop Grant and back (R3)
        stop_req = 1; steps(2, "R2");
        stop_req = 0; steps(2, "R3");
        // R2 / R10: Halt entry, clock-off ignored in Halt, exit
        halt_req = 1; steps(2, "R2");
        clk_off_async = 1; steps(4, "R10");
        clk_off_async = 0; steps(3, "R10");
        stop_req = 1; steps(2, "R2");
        stop_req = 0; halt_req = 0; steps(2, "R2");
        halt_req = 1; steps(2, "R2");
        halt_req = 0; steps(2, "R2");
        // R4 / R5: interrupts in Stop Grant are latched only
        stop_req = 1; steps(2, "R4");
        irq_nmi = 1; step("R4"); irq_nmi = 0; step("R4");
        irq_init = 1; step("R4"); irq_init = 0; step("R4");
        irq_intr = 1; steps(2, "R5"); irq_intr = 0; step("R5");
        irq_enable = 1; irq_intr = 1; step("R5"); irq_intr = 0; steps(3, "R6");
        // R6: return to Normal, service pulse, edge during the pulse
        stop_req = 0; steps(2, "R6");
        irq_flush = 1; step("R6"); irq_flush = 0; steps(4, "R6");
        irq_smi = 1; step("R6"); irq_smi = 0; steps(4, "R6");
        // R7 / R8 / R9: dirty inquire from Halt with delayed writeback
        halt_req = 1; steps(2, "R7");
        snoop_stb = 1; snoop_hit = 1; snoop_dirty = 1; step("R7");
        snoop_stb = 0; snoop_hit = 0; snoop_dirty = 0; steps(3, "R8");
        wb_done = 1; step("R9"); wb_done = 0; steps(2, "R9");
        halt_req = 0; steps(2, "R2");
        // R7: inquire in Normal, clean hit and miss in Stop Grant
        snoop_stb = 1; snoop_hit = 1; step("R7"); snoop_stb = 0; snoop_hit = 0; step("R7");
        stop_req = 1; steps(2, "R7");
        snoop_stb = 1; snoop_hit = 1; step("R7"); snoop_stb = 0; snoop_hit = 0; steps(2, "R9");
        snoop_stb = 1; step("R9"); snoop_stb = 0; steps(2, "R9");
        // R7: inquire coincides with a dropped stop request
        snoop_stb = 1; snoop_hit = 1; snoop_dirty = 1; stop_req = 0; step("R7");
        snoop_stb = 0; snoop_hit = 0; snoop_dirty = 0; steps(2, "R9");
        wb_done = 1; step("R9"); wb_done = 0; steps(3, "R3");
        // R10 / R11 / R12: Stop Clock entry, intr ignored, violation, exit
        stop_req = 1; steps(2, "R10");
        clk_off_async = 1; steps(4, "R10");
        irq_intr = 1; steps(3, "R11");
        irq_nmi = 1; steps(2, "R12");
        irq_nmi = 0; steps(2, "R12");
        clk_off_async = 0; steps(4, "R11");
        irq_intr = 0; steps(2, "R11");
        // R1: reset taken from Stop Grant
        rst_n = 0; step("R1");
        rst_n = 1; stop_req = 0; irq_enable = 0; steps(3, "R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule